// File: doc/BRIEF.md
# Two-Dimensional Nested Page Walker

This block resolves a translation miss entirely in hardware. Given a guest virtual address, it walks a four-level guest page-table hierarchy that maps virtual addresses to guest-physical addresses. Every guest table pointer, and the final guest-physical address, is itself a guest-physical address. In nested mode each of these is translated through a four-level host hierarchy that maps guest-physical to machine addresses before it is used. In native mode only the guest hierarchy is walked, and its root and pointers are taken as machine addresses.

The block has one memory read port with a single outstanding read. It reports one of three outcomes: a machine address, a guest fault, or a nested fault together with the guest-physical address that failed. It also counts the reads of the walk, so a memory system can see the cost of a miss: 4 reads when native and 24 when nested. A flush input abandons the current walk, as is needed when the address space changes on a context switch.

Top module: `nested_walker`

## Requirements
- R1: `miss_ready` is high only when the walker is idle and `flush` is low. A miss is taken on a cycle with `miss_valid` and `miss_ready` both high. A `miss_valid` raised while a walk runs is ignored and causes no reads and no result.
- R2: Native mode (`miss_nested` = 0) issues exactly 4 reads. Each read goes to the current table base with the level index times 8 added. The next base is the frame field, bits [51:12] of the returned entry. The result is that frame joined to the 12-bit page offset.
- R3: Nested mode issues exactly 24 reads, in this order. For each of the 4 guest levels there is a 4-read host walk of the guest entry's guest-physical address, followed by 1 read of the guest entry at the translated machine address. A final 4-read host walk then translates the resulting guest-physical address.
- R4: The level indices, from root to leaf, are address bits [47:39], [38:30], [29:21] and [20:12]. The same fields are used for guest-physical addresses in the host walk.
- R5: Bits [11:0] of the virtual address pass unchanged into bits [11:0] of the result. Entry bits [63:52] and [11:1] are ignored.
- R6: A guest entry with bit 0 (present) clear ends the walk at once. It reports fault code 1 and a result of 0.
- R7: A host entry with bit 0 clear ends the walk at once. It reports fault code 2, and the result is the guest-physical address being translated. A successful walk reports code 0.
- R8: At most one read is outstanding. A request holds its address until `rd_ready`. No new request is made until the read data of the previous one returns.
- R9: `walk_done` is a one-cycle pulse. It is raised only on the cycle after a response, and the fault code and result are valid with it.
- R10: At `walk_done`, `walk_refs` equals the number of reads issued for that walk.
- R11: `flush` abandons a walk without a `walk_done`. If a read is outstanding, the walker waits for its data before it becomes idle again. A following walk is unaffected.
- R12: After reset the walker is idle. `miss_ready` is 1, and `rd_valid`, `walk_done`, `walk_fault` and `walk_refs` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| miss_valid | input | 1 | Miss request valid |
| miss_ready | output | 1 | Walker idle, can take a miss |
| miss_va | input | 48 | Guest virtual address |
| miss_groot | input | 52 | Guest root table base (guest-physical, or machine when native) |
| miss_nroot | input | 52 | Host root table base (machine address) |
| miss_nested | input | 1 | 1 = two-dimensional walk, 0 = native walk |
| flush | input | 1 | Abandon the current walk |
| rd_valid | output | 1 | Read request valid |
| rd_ready | input | 1 | Read request taken |
| rd_addr | output | 52 | Byte address of the 64-bit entry to read |
| rd_rsp_valid | input | 1 | Read data valid |
| rd_rsp_data | input | 64 | Entry read |
| walk_done | output | 1 | One-cycle completion pulse |
| walk_fault | output | 2 | 0 none, 1 guest fault, 2 nested fault |
| walk_addr | output | 52 | Machine address, or faulting guest-physical address |
| walk_refs | output | 5 | Reads issued by the last walk |

## Verification
Native and nested walks run over a memory whose entries are a hash of their address. Every read address is therefore unique and order-sensitive, and a swapped level, index field or stage shows up on the first wrong read. The virtual addresses used have indices of all ones, all zeros and alternating patterns, and an all-ones offset, which separates the four index fields from one another and from the offset. Faults are placed at chosen reads: the first and third guest levels, and the first, a middle and the final host walks. These distinguish the two fault codes, the reported guest-physical address and the early end of the count. Random read stalls and response latency, a miss raised while busy, and a flush with a read in flight check the handshake rules.

// File: rtl/nested_walker.sv
module nested_walker #(
  parameter int VA_W   = 48,
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int ENT_W  = 64,
  parameter int CNT_W  = $clog2(LEVELS*(LEVELS+2)+1)
)(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             miss_valid,
  output logic             miss_ready,
  input  logic [VA_W-1:0]  miss_va,
  input  logic [PA_W-1:0]  miss_groot,
  input  logic [PA_W-1:0]  miss_nroot,
  input  logic             miss_nested,
  input  logic             flush,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [PA_W-1:0]  rd_addr,
  input  logic             rd_rsp_valid,
  input  logic [ENT_W-1:0] rd_rsp_data,
  output logic             walk_done,
  output logic [1:0]       walk_fault,
  output logic [PA_W-1:0]  walk_addr,
  output logic [CNT_W-1:0] walk_refs
);

  localparam int LVL_W = (LEVELS > 1) ? $clog2(LEVELS) : 1;
  localparam int ENT_B = $clog2(ENT_W/8);
  localparam int FRM_W = PA_W - OFF_W;
  localparam logic [LVL_W-1:0] LAST_LVL = LVL_W'(LEVELS-1);
  localparam logic [1:0] FLT_NONE = 2'd0, FLT_GUEST = 2'd1, FLT_NEST = 2'd2;

  typedef enum logic [1:0] {S_IDLE, S_ISSUE, S_WAIT, S_DRAIN} st_t;

  st_t              st_q;
  logic [VA_W-1:0]  va_q;
  logic [PA_W-1:0]  nroot_q, gbase_q, nbase_q, gpa_q;
  logic             nest_q, in_nest_q, last_q;
  logic [LVL_W-1:0] gl_q, nl_q;
  logic             done_q;
  logic [1:0]       fault_q;
  logic [PA_W-1:0]  res_q;
  logic [CNT_W-1:0] refs_q;

  logic [PA_W-1:0]  va_x, n_addr, g_addr, g_next_gpa, ent_base;
  logic [FRM_W-1:0] ent_frm;
  logic             ent_ok;
  logic [LVL_W-1:0] gl_nx;
  logic             unused_bits;

  function automatic logic [IDX_W-1:0] idx_at(input logic [PA_W-1:0] a, input logic [LVL_W-1:0] lvl);
    logic [PA_W-1:0] s;
    s = a >> (OFF_W + IDX_W*(LEVELS-1-int'(lvl)));
    return s[IDX_W-1:0];
  endfunction

  assign va_x        = {{(PA_W-VA_W){1'b0}}, va_q};
  assign ent_ok      = rd_rsp_data[0];
  assign ent_frm     = rd_rsp_data[PA_W-1:OFF_W];
  assign ent_base    = {ent_frm, {OFF_W{1'b0}}};
  assign unused_bits = ^{rd_rsp_data[ENT_W-1:PA_W], rd_rsp_data[OFF_W-1:1]};
  assign gl_nx       = gl_q + LVL_W'(1);

  assign n_addr     = {nbase_q[PA_W-1:OFF_W], idx_at(gpa_q, nl_q), {ENT_B{1'b0}}};
  assign g_addr     = nest_q ? {nbase_q[PA_W-1:OFF_W], gpa_q[OFF_W-1:0]}
                             : {gbase_q[PA_W-1:OFF_W], idx_at(va_x, gl_q), {ENT_B{1'b0}}};
  assign g_next_gpa = {ent_frm, idx_at(va_x, gl_nx), {ENT_B{1'b0}}};

  assign rd_addr    = in_nest_q ? n_addr : g_addr;
  assign rd_valid   = (st_q == S_ISSUE);
  assign miss_ready = (st_q == S_IDLE) && !flush;
  assign walk_done  = done_q;
  assign walk_fault = fault_q;
  assign walk_addr  = res_q;
  assign walk_refs  = refs_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= S_IDLE;
      va_q <= '0; nroot_q <= '0; gbase_q <= '0; nbase_q <= '0; gpa_q <= '0;
      nest_q <= 1'b0; in_nest_q <= 1'b0; last_q <= 1'b0;
      gl_q <= '0; nl_q <= '0;
      done_q <= 1'b0; fault_q <= FLT_NONE; res_q <= '0; refs_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (rd_valid && rd_ready)
        refs_q <= refs_q + CNT_W'(1);
      if (flush) begin
        unique case (st_q)
          S_ISSUE:         st_q <= rd_ready ? S_DRAIN : S_IDLE;
          S_WAIT, S_DRAIN: st_q <= rd_rsp_valid ? S_IDLE : S_DRAIN;
          default:         st_q <= S_IDLE;
        endcase
      end else begin
        unique case (st_q)
          S_IDLE: if (miss_valid) begin
            va_q      <= miss_va;
            nroot_q   <= miss_nroot;
            nest_q    <= miss_nested;
            in_nest_q <= miss_nested;
            gbase_q   <= miss_groot;
            nbase_q   <= miss_nroot;
            gpa_q     <= {miss_groot[PA_W-1:OFF_W],
                          idx_at({{(PA_W-VA_W){1'b0}}, miss_va}, '0), {ENT_B{1'b0}}};
            gl_q      <= '0;
            nl_q      <= '0;
            last_q    <= 1'b0;
            fault_q   <= FLT_NONE;
            res_q     <= '0;
            refs_q    <= '0;
            st_q      <= S_ISSUE;
          end
          S_ISSUE: if (rd_ready) st_q <= S_WAIT;
          S_WAIT: if (rd_rsp_valid) begin
            st_q <= S_ISSUE;
            if (in_nest_q) begin
              if (!ent_ok) begin
                done_q <= 1'b1; fault_q <= FLT_NEST; res_q <= gpa_q; st_q <= S_IDLE;
              end else begin
                nbase_q <= ent_base;
                if (nl_q == LAST_LVL) begin
                  if (last_q) begin
                    done_q <= 1'b1; res_q <= {ent_frm, gpa_q[OFF_W-1:0]}; st_q <= S_IDLE;
                  end else begin
                    in_nest_q <= 1'b0;
                  end
                end else begin
                  nl_q <= nl_q + LVL_W'(1);
                end
              end
            end else begin
              if (!ent_ok) begin
                done_q <= 1'b1; fault_q <= FLT_GUEST; res_q <= '0; st_q <= S_IDLE;
              end else if (gl_q == LAST_LVL) begin
                if (!nest_q) begin
                  done_q <= 1'b1; res_q <= {ent_frm, va_q[OFF_W-1:0]}; st_q <= S_IDLE;
                end else begin
                  gpa_q     <= {ent_frm, va_q[OFF_W-1:0]};
                  last_q    <= 1'b1;
                  in_nest_q <= 1'b1;
                  nl_q      <= '0;
                  nbase_q   <= nroot_q;
                end
              end else begin
                gl_q    <= gl_nx;
                gbase_q <= ent_base;
                if (nest_q) begin
                  gpa_q     <= g_next_gpa;
                  in_nest_q <= 1'b1;
                  nl_q      <= '0;
                  nbase_q   <= nroot_q;
                end
              end
            end
          end
          S_DRAIN: if (rd_rsp_valid) st_q <= S_IDLE;
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/nested_walker_props.sv
module nested_walker_props #(
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  parameter int CNT_W  = 5
)(
  input logic             clk,
  input logic             rst_n,
  input logic             miss_valid,
  input logic             miss_ready,
  input logic             flush,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [PA_W-1:0]  rd_addr,
  input logic             rd_rsp_valid,
  input logic             walk_done,
  input logic [1:0]       walk_fault,
  input logic [CNT_W-1:0] walk_refs,
  input logic             nest_q
);

  a_r1_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && miss_ready) |=> !miss_ready);

  a_r8_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready && !flush) |=> (rd_valid && $stable(rd_addr)));

  a_r8_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && rd_ready) |=> !rd_valid);

  a_r9_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |=> !walk_done);

  a_r9_done_after_data: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> $past(rd_rsp_valid));

  a_r6_fault_code: assert property (@(posedge clk) disable iff (!rst_n)
    walk_done |-> (walk_fault != 2'd3));

  a_r2_native_refs: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault == 2'd0 && !nest_q) |-> (int'(walk_refs) == LEVELS));

  a_r3_nested_refs: assert property (@(posedge clk) disable iff (!rst_n)
    (walk_done && walk_fault == 2'd0 && nest_q) |-> (int'(walk_refs) == LEVELS*(LEVELS+2)));

  a_r11_flush_no_done: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> !walk_done);

endmodule

bind nested_walker nested_walker_props #(.PA_W(PA_W), .LEVELS(LEVELS), .CNT_W(CNT_W)) i_props (
  .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
  .flush(flush), .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr),
  .rd_rsp_valid(rd_rsp_valid), .walk_done(walk_done), .walk_fault(walk_fault),
  .walk_refs(walk_refs), .nest_q(nest_q)
);

// File: tb/test_nested_walker.sv
module test_nested_walker;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        miss_valid = 1'b0;
  logic        miss_ready;
  logic [47:0] miss_va = '0;
  logic [51:0] miss_groot = '0;
  logic [51:0] miss_nroot = '0;
  logic        miss_nested = 1'b0;
  logic        flush = 1'b0;
  logic        rd_valid;
  logic        rd_ready = 1'b0;
  logic [51:0] rd_addr;
  logic        rd_rsp_valid = 1'b0;
  logic [63:0] rd_rsp_data = '0;
  logic        walk_done;
  logic [1:0]  walk_fault;
  logic [51:0] walk_addr;
  logic [4:0]  walk_refs;

  nested_walker i_nested_walker (
    .clk(clk), .rst_n(rst_n), .miss_valid(miss_valid), .miss_ready(miss_ready),
    .miss_va(miss_va), .miss_groot(miss_groot), .miss_nroot(miss_nroot),
    .miss_nested(miss_nested), .flush(flush), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .walk_done(walk_done), .walk_fault(walk_fault), .walk_addr(walk_addr), .walk_refs(walk_refs)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit finished = 0;
  string cur_req = "R2";

  bit          bad [logic [51:0]];
  logic [51:0] m_addrs [$];
  logic [51:0] exp_addr [$];
  logic [1:0]  exp_f [$];
  logic [51:0] exp_r [$];
  int          exp_n [$];

  bit          pending = 0;
  bit          stall_rsp = 0;
  logic [51:0] pend_addr = '0;
  int          lat = 0;
  logic [15:0] lfsr = 16'hACE1;
  bit          prev_done = 0;
  bit          prev_wait = 0;
  logic [51:0] prev_addr = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  function automatic logic [8:0] bidx(input logic [51:0] a, input int l);
    logic [51:0] s;
    s = a >> (12 + 9*(3-l));
    return s[8:0];
  endfunction

  function automatic logic [63:0] mem_entry(input logic [51:0] a);
    logic [63:0] p;
    if (bad.exists(a)) return 64'hABC0_0000_0000_0B4A;
    p = {12'h0, a} * 64'h9E37_79B9_7F4A_7C15;
    return {12'hABC, p[59:20], 12'h5A5};
  endfunction

  task automatic host_walk(input logic [51:0] gpa, input logic [51:0] nroot,
                           output bit ok, output logic [51:0] ma);
    logic [51:0] base, a;
    logic [63:0] e;
    base = nroot; ok = 1; ma = '0;
    for (int l = 0; l < 4; l++) begin
      a = {base[51:12], bidx(gpa, l), 3'b000};
      m_addrs.push_back(a);
      e = mem_entry(a);
      if (!e[0]) begin ok = 0; return; end
      base = {e[51:12], 12'h000};
    end
    ma = {base[51:12], gpa[11:0]};
  endtask

  task automatic model(input logic [47:0] va, input logic [51:0] groot, input logic [51:0] nroot,
                       input bit nested, output logic [1:0] f, output logic [51:0] r);
    logic [51:0] tbl, ea, ma, leaf;
    logic [63:0] e;
    bit ok;
    m_addrs.delete();
    tbl = groot; f = 2'd0; r = '0;
    for (int g = 0; g < 4; g++) begin
      ea = {tbl[51:12], bidx({4'h0, va}, g), 3'b000};
      if (nested) begin
        host_walk(ea, nroot, ok, ma);
        if (!ok) begin f = 2'd2; r = ea; return; end
        ea = ma;
      end
      m_addrs.push_back(ea);
      e = mem_entry(ea);
      if (!e[0]) begin f = 2'd1; r = '0; return; end
      tbl = {e[51:12], 12'h000};
    end
    leaf = {tbl[51:12], va[11:0]};
    if (nested) begin
      host_walk(leaf, nroot, ok, ma);
      if (!ok) begin f = 2'd2; r = leaf; return; end
      r = ma;
    end else begin
      r = leaf;
    end
  endtask

  task automatic start_miss(input logic [47:0] va, input logic [51:0] groot,
                            input logic [51:0] nroot, input bit nested);
    @(negedge clk);
    while (!miss_ready) @(negedge clk);
    miss_valid = 1; miss_va = va; miss_groot = groot; miss_nroot = nroot; miss_nested = nested;
    @(negedge clk);
    miss_valid = 0;
  endtask

  task automatic run_walk(input logic [47:0] va, input logic [51:0] groot,
                          input logic [51:0] nroot, input bit nested, input bit poke);
    logic [1:0] f;
    logic [51:0] r;
    model(va, groot, nroot, nested, f, r);
    foreach (m_addrs[i]) exp_addr.push_back(m_addrs[i]);
    exp_f.push_back(f); exp_r.push_back(r); exp_n.push_back(m_addrs.size());
    start_miss(va, groot, nroot, nested);
    if (poke) begin
      repeat (2) @(negedge clk);
      miss_valid = 1; miss_va = ~va; miss_nested = ~nested;
      for (int k = 0; k < 3; k++) begin
        @(negedge clk);
        check(miss_ready == 1'b0, "R1", "ready while busy", miss_ready, 0);
      end
      miss_valid = 0;
    end
    while (exp_f.size() != 0) @(negedge clk);
    repeat (6) @(negedge clk);
    check(exp_addr.size() == 0, cur_req, "reads left unissued", exp_addr.size(), 0);
  endtask

  task automatic fault_walk(input logic [47:0] va, input logic [51:0] groot,
                            input logic [51:0] nroot, input bit nested, input int k);
    logic [1:0] f;
    logic [51:0] r;
    model(va, groot, nroot, nested, f, r);
    bad[m_addrs[k]] = 1;
    run_walk(va, groot, nroot, nested, 0);
    bad.delete();
  endtask

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      cycles++;
      if (cycles > 100000) begin
        finished = 1;
        errors++; checks++;
        $display("FAIL watchdog actual=%0d expected=%0d", cycles, 100000);
        finish_run();
      end
      rd_rsp_valid = 0;
      if (pending) begin
        if (lat != 0) lat--;
        else if (!stall_rsp) begin
          rd_rsp_valid = 1; rd_rsp_data = mem_entry(pend_addr); pending = 0;
        end
      end
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      rd_ready = lfsr[0] | lfsr[3];
      if (rd_valid) begin
        check(!pending, "R8", "request while read outstanding", 1, 0);
        if (prev_wait)
          check(rd_addr == prev_addr, "R8", "address changed while stalled", rd_addr, prev_addr);
        if (rd_ready) begin
          if (exp_addr.size() == 0) check(0, "R1", "unexpected read", rd_addr, 0);
          else begin
            logic [51:0] e;
            e = exp_addr.pop_front();
            check(rd_addr == e, cur_req, "read address", rd_addr, e);
          end
          pending = 1; pend_addr = rd_addr; lat = int'(lfsr[2:1]);
        end
      end
      prev_wait = rd_valid && !rd_ready;
      prev_addr = rd_addr;
      if (walk_done) begin
        check(!prev_done, "R9", "done longer than one cycle", 1, 0);
        if (exp_f.size() == 0) check(0, "R11", "unexpected done", 1, 0);
        else begin
          logic [1:0] ef; logic [51:0] er; int en;
          ef = exp_f.pop_front(); er = exp_r.pop_front(); en = exp_n.pop_front();
          check(walk_fault == ef, (ef == 2'd1) ? "R6" : "R7", "fault code", walk_fault, ef);
          check(walk_addr == er, cur_req, "result address", walk_addr, er);
          check(int'(walk_refs) == en, "R10", "read count", walk_refs, en);
        end
      end
      prev_done = walk_done;
    end
  end

  initial begin
    logic [1:0] f;
    logic [51:0] r;
    repeat (3) @(negedge clk);
    check(miss_ready == 1'b1, "R12", "ready in reset", miss_ready, 1);
    rst_n = 1;
    @(negedge clk);
    check(miss_ready == 1'b1, "R12", "ready after reset", miss_ready, 1);
    check(rd_valid == 1'b0, "R12", "read valid after reset", rd_valid, 0);
    check(walk_done == 1'b0, "R12", "done after reset", walk_done, 0);
    check(walk_fault == 2'd0, "R12", "fault after reset", walk_fault, 0);
    check(walk_refs == 5'd0, "R12", "refs after reset", walk_refs, 0);

    cur_req = "R2";
    run_walk(48'h1234_5678_9ABC, 52'h0_0001_2345_6000, 52'h0, 0, 0);
    cur_req = "R4";
    run_walk({9'h1FF, 9'h000, 9'h155, 9'h0AA, 12'h3C5}, 52'hF_0000_0000_1000, 52'h0, 0, 0);
    cur_req = "R3";
    run_walk(48'h7FFF_0123_4567, 52'h0_0000_8888_8000, 52'h0_0000_4444_4000, 1, 1);
    cur_req = "R5";
    run_walk({9'h0AA, 9'h155, 9'h000, 9'h1FF, 12'hFFF}, 52'h0_ABCD_0000_0000, 52'h3_0000_0000_0000, 1, 0);
    cur_req = "R4";
    run_walk(48'h0000_0000_0000, 52'h0, 52'h0_0000_0000_1000, 1, 0);

    cur_req = "R6";
    fault_walk(48'h0102_0304_0506, 52'h0_0000_2000_0000, 52'h0, 0, 2);
    fault_walk(48'h0102_0304_0506, 52'h0_0000_2000_0000, 52'h0_0000_3000_0000, 1, 14);
    fault_walk(48'hFEDC_BA98_7654, 52'h0_0000_2100_0000, 52'h0, 0, 0);
    cur_req = "R7";
    fault_walk(48'h0102_0304_0506, 52'h0_0000_2000_0000, 52'h0_0000_3000_0000, 1, 21);
    fault_walk(48'hFEDC_BA98_7654, 52'h0_0000_2100_0000, 52'h0_0000_3100_0000, 1, 1);
    fault_walk(48'h5555_AAAA_5555, 52'h0_0000_2200_0000, 52'h0_0000_3200_0000, 1, 7);

    cur_req = "R11";
    model(48'h4444_3333_2222, 52'h0_0000_5000_0000, 52'h0_0000_6000_0000, 1, f, r);
    exp_addr.push_back(m_addrs[0]);
    stall_rsp = 1;
    start_miss(48'h4444_3333_2222, 52'h0_0000_5000_0000, 52'h0_0000_6000_0000, 1);
    while (!pending) @(negedge clk);
    repeat (2) @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    check(miss_ready == 1'b0, "R11", "idle before drain", miss_ready, 0);
    check(rd_valid == 1'b0, "R11", "read after flush", rd_valid, 0);
    stall_rsp = 0;
    repeat (8) @(negedge clk);
    check(miss_ready == 1'b1, "R11", "idle after drain", miss_ready, 1);
    check(walk_fault == 2'd0 && walk_addr == '0, "R11", "stale result", walk_addr, 0);
    run_walk(48'h4444_3333_2222, 52'h0_0000_5000_0000, 52'h0_0000_6000_0000, 1, 0);

    finished = 1;
    finish_run();
  end

endmodule